// File: doc/BRIEF.md
# Indirect-Indexed Codec Register Interface

This block is the control register file of an audio codec. It sits on a 32-bit bus with a 6-bit byte address. The address selects one of sixteen word-wide direct registers. Direct word 0 holds a pointer, and direct word 1 is a window onto thirty-two 8-bit indirect registers chosen by the low five pointer bits. Software reaches every indirect setting by first writing the pointer and then reading or writing the window.

A few locations behave in a special way:
- One indirect slot always reads as zero.
- Two indirect slots ignore writes.
- One indirect slot keeps a single writable bit beside a fixed revision code.
- One direct word discards writes.
- A bit in a control word restores the whole block to its reset values in the same cycle as the control word stores its own masked value.

Reads are taken from the current register state into a registered read-data output. That output changes only on cycles with the read strobe. Reset is synchronous and active high.

Top module: `codec_idx_regs`

## Requirements
- R1: The direct word index is byte address bits [5:2]; address bits [1:0] have no effect on reads or writes.
- R2: After reset every direct word reads 0 and every indirect slot reads 0, except indirect slot 12, which reads 0x8A, and indirect slot 25, which reads 0xA0.
- R3: Bits [4:0] of direct word 0 select the indirect slot. A window write stores wdata[7:0] into that slot. A window read returns the slot value zero-extended to 32 bits.
- R4: A window read while the pointer is 3 returns 0, whatever slot 3 holds.
- R5: Window writes while the pointer is 11 or 25 leave those slots unchanged.
- R6: A window write while the pointer is 12 stores (wdata & 0x40) | 0x8A.
- R7: Writes to direct word 2 are discarded, so it always reads 0.
- R8: A write to direct word 4 with wdata[0] = 1 restores every register to its R2 value. In the same cycle, word 4 stores wdata & 0x7F. A write to word 4 with wdata[0] = 0 only stores wdata & 0x7F.
- R9: Writes to direct words 0, 3 and 5..15 store all 32 bits, and reads of those words return the stored word.
- R10: rdata is loaded one clock after a cycle with rd_en = 1, with the value from before any write in that same cycle. With rd_en = 0, rdata holds its value. Reset clears rdata to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe, loads rdata at the next edge |
| addr | input | 6 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
Every direct word is written with a distinct multiplicative pattern, using varied low address bits, and read back. This separates per-word storage from the discarded and masked words. Every indirect slot is then selected through a pointer whose upper bits carry noise, written with an index-derived byte, and read back twice. This shows the slot selection, the locked slots, the masked revision slot and the zero-read slot at their own indices. Soft-reset writes with bit 0 set and clear, a same-cycle read and write, and idle cycles after a read separate the soft-reset ordering and the read-data timing from plain storage.

// File: rtl/codec_idx_pkg.sv
package codec_idx_pkg;
  localparam int unsigned SLOT_W   = 8;
  localparam int unsigned SLOT_AW  = 5;
  localparam int unsigned NUM_SLOT = 1 << SLOT_AW;

  localparam int unsigned W_PTR  = 0;
  localparam int unsigned W_WIN  = 1;
  localparam int unsigned W_SINK = 2;
  localparam int unsigned W_CTRL = 4;

  localparam logic [SLOT_AW-1:0] S_ZERO_RD = 5'd3;
  localparam logic [SLOT_AW-1:0] S_LOCK    = 5'd11;
  localparam logic [SLOT_AW-1:0] S_REV     = 5'd12;
  localparam logic [SLOT_AW-1:0] S_ID      = 5'd25;

  localparam logic [SLOT_W-1:0] REV_CODE = 8'h8A;
  localparam logic [SLOT_W-1:0] REV_WMSK = 8'h40;
  localparam logic [SLOT_W-1:0] ID_CODE  = 8'hA0;
  localparam logic [6:0]        CTRL_MSK = 7'h7F;

  function automatic logic [SLOT_W-1:0] slot_reset_value(input logic [SLOT_AW-1:0] idx);
    if (idx == S_REV) return REV_CODE;
    if (idx == S_ID)  return ID_CODE;
    return '0;
  endfunction

  function automatic logic slot_locked(input logic [SLOT_AW-1:0] idx);
    return (idx == S_LOCK) || (idx == S_ID);
  endfunction

  function automatic logic [SLOT_W-1:0] slot_store_value(input logic [SLOT_AW-1:0] idx,
                                                         input logic [SLOT_W-1:0]  d);
    if (idx == S_REV) return (d & REV_WMSK) | REV_CODE;
    return d;
  endfunction

  function automatic logic [SLOT_W-1:0] slot_read_value(input logic [SLOT_AW-1:0] idx,
                                                        input logic [SLOT_W-1:0]  q);
    if (idx == S_ZERO_RD) return '0;
    return q;
  endfunction
endpackage

// File: rtl/codec_idx_decode.sv
module codec_idx_decode
  import codec_idx_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned WORD_W = ADDR_W - 2,
  localparam int unsigned NUM_W  = 1 << WORD_W
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [SLOT_AW-1:0]   ptr,
  output logic [WORD_W-1:0]    word_idx,
  output logic [NUM_W-1:0]     dir_sel,
  output logic [DATA_W-1:0]    ctrl_data,
  output logic [NUM_SLOT-1:0]  slot_sel,
  output logic [SLOT_W-1:0]    slot_data,
  output logic                 win_wr_evt,
  output logic                 win_drop_evt,
  output logic                 sink_wr_evt,
  output logic                 soft_rst_evt
);
  logic unused_low;
  assign unused_low = ^addr[1:0];

  assign word_idx = addr[ADDR_W-1:2];

  logic is_win, is_sink, is_ctrl;
  assign is_win  = (word_idx == WORD_W'(W_WIN));
  assign is_sink = (word_idx == WORD_W'(W_SINK));
  assign is_ctrl = (word_idx == WORD_W'(W_CTRL));

  assign win_wr_evt   = wr_en && is_win;
  assign win_drop_evt = win_wr_evt && slot_locked(ptr);
  assign sink_wr_evt  = wr_en && is_sink;
  assign soft_rst_evt = wr_en && is_ctrl && wdata[0];

  always_comb begin
    dir_sel = '0;
    if (wr_en && !is_win && !is_sink) dir_sel[word_idx] = 1'b1;
  end

  always_comb begin
    slot_sel = '0;
    if (win_wr_evt && !win_drop_evt) slot_sel[ptr] = 1'b1;
  end

  assign ctrl_data = DATA_W'(wdata[6:0] & CTRL_MSK);
  assign slot_data = slot_store_value(ptr, wdata[SLOT_W-1:0]);
endmodule

// File: rtl/codec_idx_direct.sv
module codec_idx_direct
  import codec_idx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         soft_clr,
  input  logic [NUM_W-1:0]             sel,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [DATA_W-1:0]            ctrl_data,
  output logic [NUM_W-1:0][DATA_W-1:0] q
);
  logic unused_sel;
  assign unused_sel = sel[W_WIN] ^ sel[W_SINK];

  for (genvar w = 0; w < NUM_W; w++) begin : g_word
    if (w == W_WIN || w == W_SINK) begin : g_none
      assign q[w] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)           r <= '0;
        else if (sel[w])   r <= (w == W_CTRL) ? ctrl_data : wdata;
        else if (soft_clr) r <= '0;
      end
      assign q[w] = r;
    end
  end
endmodule

// File: rtl/codec_idx_slots.sv
module codec_idx_slots
  import codec_idx_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           soft_clr,
  input  logic [NUM_SLOT-1:0]            sel,
  input  logic [SLOT_W-1:0]              wdata,
  output logic [NUM_SLOT-1:0][SLOT_W-1:0] q
);
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    localparam logic [SLOT_W-1:0] RV = slot_reset_value(SLOT_AW'(s));
    logic [SLOT_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst || soft_clr) r <= RV;
      else if (sel[s])     r <= wdata;
    end
    assign q[s] = r;
  end
endmodule

// File: rtl/codec_idx_regs.sv
module codec_idx_regs
  import codec_idx_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned NUM_W  = 1 << WORD_W;

  logic [NUM_W-1:0][DATA_W-1:0]   dir_q;
  logic [NUM_SLOT-1:0][SLOT_W-1:0] slot_q;
  logic [WORD_W-1:0]   word_idx;
  logic [NUM_W-1:0]    dir_sel;
  logic [DATA_W-1:0]   ctrl_data;
  logic [NUM_SLOT-1:0] slot_sel;
  logic [SLOT_W-1:0]   slot_data;
  logic win_wr_evt, win_drop_evt, sink_wr_evt, soft_rst_evt;
  logic [SLOT_AW-1:0]  ptr;
  logic [DATA_W-1:0]   rd_next;

  assign ptr = dir_q[W_PTR][SLOT_AW-1:0];

  codec_idx_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_decode (
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .ptr(ptr),
    .word_idx(word_idx), .dir_sel(dir_sel), .ctrl_data(ctrl_data),
    .slot_sel(slot_sel), .slot_data(slot_data),
    .win_wr_evt(win_wr_evt), .win_drop_evt(win_drop_evt),
    .sink_wr_evt(sink_wr_evt), .soft_rst_evt(soft_rst_evt)
  );

  codec_idx_direct #(.DATA_W(DATA_W), .NUM_W(NUM_W)) i_direct (
    .clk(clk), .rst(rst), .soft_clr(soft_rst_evt), .sel(dir_sel),
    .wdata(wdata), .ctrl_data(ctrl_data), .q(dir_q)
  );

  codec_idx_slots i_slots (
    .clk(clk), .rst(rst), .soft_clr(soft_rst_evt), .sel(slot_sel),
    .wdata(slot_data), .q(slot_q)
  );

  always_comb begin
    if (word_idx == WORD_W'(W_WIN)) rd_next = DATA_W'(slot_read_value(ptr, slot_q[ptr]));
    else                            rd_next = dir_q[word_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/codec_idx_regs_chk.sv
module codec_idx_regs_chk
  import codec_idx_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            rd_en,
  input logic [ADDR_W-1:0]               addr,
  input logic [DATA_W-1:0]               wdata,
  input logic [DATA_W-1:0]               rdata,
  input logic [SLOT_AW-1:0]              ptr,
  input logic [DATA_W-1:0]               ctrl_word,
  input logic [NUM_SLOT-1:0][SLOT_W-1:0] slot_q,
  input logic                            win_wr_evt,
  input logic                            win_drop_evt,
  input logic                            sink_wr_evt,
  input logic                            soft_rst_evt
);
  logic rd_win, rd_sink;
  assign rd_win  = rd_en && (addr[ADDR_W-1:2] == (ADDR_W-2)'(W_WIN));
  assign rd_sink = rd_en && (addr[ADDR_W-1:2] == (ADDR_W-2)'(W_SINK));

  AST_ZERO_SLOT_READ: assert property (@(posedge clk) disable iff (rst)
    rd_win && ptr == S_ZERO_RD |=> rdata == '0); // R4
  AST_LOCKED_SLOT_KEPT: assert property (@(posedge clk) disable iff (rst)
    win_drop_evt && !soft_rst_evt |=> slot_q[$past(ptr)] == $past(slot_q[ptr])); // R5
  AST_REV_FORMAT: assert property (@(posedge clk) disable iff (rst)
    (slot_q[S_REV] & ~REV_WMSK) == REV_CODE); // R6
  AST_SLOT_STORE: assert property (@(posedge clk) disable iff (rst)
    win_wr_evt && !win_drop_evt && ptr != S_REV
      |=> slot_q[$past(ptr)] == $past(wdata[SLOT_W-1:0])); // R3
  AST_SINK_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_sink && !sink_wr_evt |=> rdata == '0); // R7
  AST_SOFT_RST_ORDER: assert property (@(posedge clk) disable iff (rst)
    soft_rst_evt |=> ptr == '0 && slot_q[S_ID] == ID_CODE
                     && ctrl_word == DATA_W'($past(wdata[6:0]))); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R10
endmodule

bind codec_idx_regs codec_idx_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .ptr(ptr), .ctrl_word(dir_q[codec_idx_pkg::W_CTRL]), .slot_q(slot_q),
  .win_wr_evt(win_wr_evt), .win_drop_evt(win_drop_evt),
  .sink_wr_evt(sink_wr_evt), .soft_rst_evt(soft_rst_evt)
);

// File: tb/test_codec_idx_regs.sv
`timescale 1ns/1ps
module test_codec_idx_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] mdir [16];
  logic [7:0]  mslot [32];

  always #4 clk = ~clk;

  codec_idx_regs i_codec_idx_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic model_reset();
    for (int k = 0; k < 16; k++) mdir[k] = 32'h0;
    for (int k = 0; k < 32; k++) mslot[k] = 8'h0;
    mslot[12] = 8'h8A;
    mslot[25] = 8'hA0;
  endtask

  function automatic logic [31:0] model_read(input logic [5:0] a);
    int w, p;
    w = int'(a) / 4;
    if (w != 1) return mdir[w];
    p = int'(mdir[0] % 32);
    if (p == 3) return 32'h0;
    return {24'h0, mslot[p]};
  endfunction

  task automatic model_write(input logic [5:0] a, input logic [31:0] d);
    int w, p;
    w = int'(a) / 4;
    p = int'(mdir[0] % 32);
    case (w)
      1: case (p)
           11, 25: ;
           12: mslot[p] = (d[7:0] & 8'h40) | 8'h8A;
           default: mslot[p] = d[7:0];
         endcase
      2: ;
      4: begin
           if (d % 2 == 1) model_reset();
           mdir[4] = d % 128;
         end
      default: mdir[w] = d;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [5:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp = model_read(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset rdata", rdata, 32'h0);
    for (int w = 0; w < 16; w++) do_read(6'(w * 4), "R2 direct reset");
    do_write(6'h00, 32'd12); do_read(6'h04, "R2 slot12 reset");
    check("R2 slot12 const", rdata, 32'h0000_008A);
    do_write(6'h00, 32'd25); do_read(6'h04, "R2 slot25 reset");
    check("R2 slot25 const", rdata, 32'h0000_00A0);

    for (int w = 0; w < 16; w++) begin
      logic [31:0] d;
      d = (32'h9E37_79B9 * 32'(w + 1)) ^ 32'(w << 8);
      if (w == 4) d = d & 32'hFFFF_FFFE;
      do_write(6'(w * 4 + (w % 4)), d);
    end
    for (int w = 0; w < 16; w++) do_read(6'(w * 4 + 3 - (w % 4)), "R1 R9 direct sweep");
    do_write(6'h08, 32'hDEAD_BEEF); do_read(6'h08, "R7 sink word");
    check("R7 sink const", rdata, 32'h0);

    for (int s = 0; s < 32; s++) begin
      do_write(6'h00, 32'hABCD_E0 << 8 | 32'(s) | 32'hE0);
      do_write(6'h05, 32'h1234_5600 | 32'(((s * 29 + 7) ^ 8'hC3) & 8'hFF));
      do_read(6'h06, "R3 R4 R5 R6 slot sweep");
    end
    for (int s = 0; s < 32; s++) begin
      do_write(6'h00, 32'(s));
      do_read(6'h04, "R3 slot readback");
    end

    do_write(6'h00, 32'd12);
    do_write(6'h04, 32'h0000_00FF); do_read(6'h04, "R6 rev ff");
    check("R6 rev ff const", rdata, 32'h0000_00CA);
    do_write(6'h04, 32'h0000_0000); do_read(6'h04, "R6 rev 00");
    check("R6 rev 00 const", rdata, 32'h0000_008A);
    do_write(6'h00, 32'd3); do_write(6'h04, 32'h55); do_read(6'h04, "R4 zero slot");
    check("R4 zero const", rdata, 32'h0);
    do_write(6'h00, 32'd11); do_write(6'h04, 32'h77); do_read(6'h04, "R5 locked 11");

    do_write(6'h10, 32'h0000_00FE); do_read(6'h10, "R8 ctrl no reset");
    check("R8 ctrl 7e", rdata, 32'h0000_007E);
    do_read(6'h14, "R8 word5 kept");
    do_write(6'h00, 32'd7); do_write(6'h04, 32'h3C);
    do_write(6'h10, 32'hFFFF_FF81);
    do_read(6'h10, "R8 ctrl after soft reset");
    check("R8 ctrl 01", rdata, 32'h0000_0001);
    do_read(6'h14, "R8 word5 cleared");
    do_read(6'h00, "R8 pointer cleared");
    do_read(6'h04, "R8 slot0 after reset");
    do_write(6'h00, 32'd7);  do_read(6'h04, "R8 slot7 cleared");
    do_write(6'h00, 32'd12); do_read(6'h04, "R8 slot12 restored");

    do_write(6'h14, 32'h1111_2222);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 6'h14; wdata = 32'h3333_4444;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R10 read old on same-cycle write", rdata, 32'h1111_2222);
    model_write(6'h14, 32'h3333_4444);
    do_write(6'h14, 32'h5555_6666);
    repeat (3) @(negedge clk);
    check("R10 rdata held", rdata, 32'h1111_2222);
    do_read(6'h14, "R10 new value");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule